// File: doc/BRIEF.md
# Generalized Bit Reversal Permuter

This block is a purely combinational bit-permutation unit for an execution pipeline. Every output bit at position i is taken from the source operand at position i XOR k, where k is a small control value. A single k can therefore reverse all bits, exchange the nibbles inside each byte, reverse the byte order, exchange the two halves, or apply any combination of these.

The control value is taken either from a register operand or from a 6-bit immediate field. A word mode permutes only the lower half of the source and returns it zero-extended. A record flag asks the unit to also produce a three-bit sign summary of the result, together with a write strobe for the condition field. Instruction decode and register file access stay outside the block.

Top module: `gbr_permuter`

## Requirements
- R1: In doubleword mode (`word_mode`=0), `result[i]` equals `src[i ^ k]` for every i from 0 to XLEN-1, with bit 0 as the least significant bit.
- R2: When `use_imm`=0, k is taken from `ctl_reg[log2(XLEN)-1:0]`. All higher bits of `ctl_reg` have no effect on `result`.
- R3: When `use_imm`=1, k is taken from `ctl_imm[log2(XLEN)-1:0]`. With XLEN=64 this is all 6 bits, and `ctl_reg` has no effect.
- R4: In word mode (`word_mode`=1), the operand is `src[XLEN/2-1:0]` and k is the low log2(XLEN)-1 bits of the selected control value. The upper source half and control bit log2(XLEN)-1 have no effect.
- R5: In word mode, `result[XLEN-1:XLEN/2]` is zero.
- R6: `cond_wr` equals `rec_en`. When `rec_en`=1, `cond_flags` is 3'b100 for a negative result (top bit set), 3'b001 for a zero result, and 3'b010 otherwise. When `rec_en`=0, `cond_flags` is 3'b000.
- R7: With XLEN=64, k=63 reverses the whole operand and k=56 reverses its byte order.
- R8: k=0 gives the operand unchanged, and applying the same k to the result restores the original operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src | input | XLEN | Source operand to permute |
| ctl_reg | input | XLEN | Register control operand; only its low bits are used |
| ctl_imm | input | 6 | Immediate control field |
| use_imm | input | 1 | 1 selects `ctl_imm`, 0 selects `ctl_reg` |
| word_mode | input | 1 | 1 permutes the lower half only and zero-fills the upper half |
| rec_en | input | 1 | Record flag: request a condition summary |
| result | output | XLEN | Permuted operand |
| cond_wr | output | 1 | Strobe for writing the condition field |
| cond_flags | output | 3 | {negative, positive, zero} summary of `result` |

## Verification
The block holds no state, so a fault in a swap stage or in the control selection shows at `result` in the same cycle the inputs change. The distance of the wrongly moved bits from their expected place points to the stage at fault. Sweeping all 64 control values in each mode, with irregular data, exposes a stuck or misrouted stage and a wrongly masked control bit. Round-trip and identity cases catch stages that are not their own inverse. Sign-summary cases cover negative, zero and positive results with the record flag both set and clear.

// File: rtl/gbr_pkg.sv
package gbr_pkg;
   localparam int COND_W   = 3;
   localparam int IMM_W    = 6;
   localparam int MAX_XLEN = 64;

   localparam logic [COND_W-1:0] FLAG_NEG  = 3'b100;
   localparam logic [COND_W-1:0] FLAG_POS  = 3'b010;
   localparam logic [COND_W-1:0] FLAG_ZERO = 3'b001;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/gbr_ctrl_sel.sv
module gbr_ctrl_sel
   import gbr_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int KW   = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]  ctl_reg,
   input  logic [IMM_W-1:0] ctl_imm,
   input  logic             use_imm,
   input  logic             word_mode,
   output logic [KW-1:0]    k
);
   logic [KW-1:0] raw;

   always_comb raw = use_imm ? ctl_imm[KW-1:0] : ctl_reg[KW-1:0];

   // the top control bit would cross the half boundary in word mode
   always_comb k = word_mode ? {1'b0, raw[KW-2:0]} : raw;

   logic unused_reg_hi;
   assign unused_reg_hi = ^ctl_reg[XLEN-1:KW];

   generate
      if (KW < IMM_W) begin : g_imm_trim
         logic unused_imm_hi;
         assign unused_imm_hi = ^ctl_imm[IMM_W-1:KW];
      end
   endgenerate
endmodule

// File: rtl/gbr_stage.sv
module gbr_stage #(
   parameter int XLEN = 64,
   parameter int DIST = 1
) (
   input  logic [XLEN-1:0] din,
   input  logic            swap,
   output logic [XLEN-1:0] dout
);
   generate
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
         localparam int PARTNER = i ^ DIST;
         assign dout[i] = swap ? din[PARTNER] : din[i];
      end
   endgenerate

   // a swap stage only moves bits, it never creates or drops ones
   always_comb begin
      assert_stage_popcount_R1: assert ($countones(dout) == $countones(din))
         else $error("stage %0d changed population count", DIST);
   end
endmodule

// File: rtl/gbr_net.sv
module gbr_net #(
   parameter int XLEN = 64,
   parameter int KW   = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] operand,
   input  logic [KW-1:0]   k,
   output logic [XLEN-1:0] permuted
);
   logic [XLEN-1:0] lvl [0:KW];

   assign lvl[0] = operand;

   generate
      for (genvar s = 0; s < KW; s++) begin : g_stage
         gbr_stage #(
            .XLEN (XLEN),
            .DIST (1 << s)
         ) u_stage (
            .din  (lvl[s]),
            .swap (k[s]),
            .dout (lvl[s+1])
         );
      end
   endgenerate

   assign permuted = lvl[KW];
endmodule

// File: rtl/gbr_cond.sv
module gbr_cond
   import gbr_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]   value,
   input  logic              rec_en,
   output logic              cond_wr,
   output logic [COND_W-1:0] cond_flags
);
   logic is_neg, is_zero;

   always_comb begin
      is_neg  = value[XLEN-1];
      is_zero = (value == '0);
      if (!rec_en)      cond_flags = '0;
      else if (is_neg)  cond_flags = FLAG_NEG;
      else if (is_zero) cond_flags = FLAG_ZERO;
      else              cond_flags = FLAG_POS;
   end

   assign cond_wr = rec_en;

   always_comb begin
      if (rec_en) begin
         assert_flags_onehot_R6: assert ($countones(cond_flags) == 1)
            else $error("condition summary not one-hot");
      end
   end
endmodule

// File: rtl/gbr_permuter.sv
module gbr_permuter
   import gbr_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]   src,
   input  logic [XLEN-1:0]   ctl_reg,
   input  logic [IMM_W-1:0]  ctl_imm,
   input  logic              use_imm,
   input  logic              word_mode,
   input  logic              rec_en,
   output logic [XLEN-1:0]   result,
   output logic              cond_wr,
   output logic [COND_W-1:0] cond_flags
);
   localparam int KW   = $clog2(XLEN);
   localparam int HALF = XLEN / 2;

   generate
      if (!is_pow2(XLEN)) begin : g_bad_pow2
         $error("XLEN must be a power of two");
      end
      if (XLEN < 4 || XLEN > MAX_XLEN) begin : g_bad_range
         $error("XLEN must lie between 4 and %0d", MAX_XLEN);
      end
   endgenerate

   logic [KW-1:0]   k;
   logic [XLEN-1:0] operand;
   logic [XLEN-1:0] permuted;

   gbr_ctrl_sel #(
      .XLEN (XLEN),
      .KW   (KW)
   ) u_ctrl (
      .ctl_reg   (ctl_reg),
      .ctl_imm   (ctl_imm),
      .use_imm   (use_imm),
      .word_mode (word_mode),
      .k         (k)
   );

   always_comb operand = word_mode ? {{HALF{1'b0}}, src[HALF-1:0]} : src;

   gbr_net #(
      .XLEN (XLEN),
      .KW   (KW)
   ) u_net (
      .operand  (operand),
      .k        (k),
      .permuted (permuted)
   );

   always_comb result = word_mode ? {{HALF{1'b0}}, permuted[HALF-1:0]} : permuted;

   gbr_cond #(
      .XLEN (XLEN)
   ) u_cond (
      .value      (result),
      .rec_en     (rec_en),
      .cond_wr    (cond_wr),
      .cond_flags (cond_flags)
   );

   always_comb begin
      if (word_mode) begin
         assert_word_upper_zero_R5: assert (result[XLEN-1:HALF] == '0)
            else $error("word mode left upper half non-zero");
      end
      if (k == '0) begin
         assert_identity_R8: assert (result == operand)
            else $error("zero control did not pass operand through");
      end
   end
endmodule

// File: tb/sim_gbr_permuter.sv
module sim_gbr_permuter;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic [63:0]     src, ctl_reg, result;
   logic [5:0]      ctl_imm;
   logic            use_imm, word_mode, rec_en, cond_wr;
   logic [2:0]      cond_flags;
   int              checks = 0;
   int              failures = 0;

   always #4 clk = ~clk;

   gbr_permuter #(.XLEN(XLEN)) u0 (
      .src(src), .ctl_reg(ctl_reg), .ctl_imm(ctl_imm), .use_imm(use_imm),
      .word_mode(word_mode), .rec_en(rec_en), .result(result),
      .cond_wr(cond_wr), .cond_flags(cond_flags)
   );

   // {src, ctl_reg, ctl_imm, use_imm, word_mode, rec_en, expected}
   localparam logic [200:0] TBL [0:7] = '{
      {64'h0123456789ABCDEF, 64'h0, 6'd0, 1'b0, 1'b0, 1'b1, 64'h0123456789ABCDEF},   // R8
      {64'h0000000000000001, 64'd63, 6'd0, 1'b0, 1'b0, 1'b1, 64'h8000000000000000},  // R7
      {64'h0123456789ABCDEF, 64'd56, 6'd0, 1'b0, 1'b0, 1'b1, 64'hEFCDAB8967452301},  // R7
      {64'h0123456789ABCDEF, 64'd0, 6'd4, 1'b1, 1'b0, 1'b1, 64'h1032547698BADCFE},   // R3
      {64'h0123456789ABCDEF, 64'd32, 6'd0, 1'b0, 1'b0, 1'b0, 64'h89ABCDEF01234567},  // R1
      {64'hFFFFFFFF00000001, 64'd63, 6'd0, 1'b0, 1'b1, 1'b1, 64'h0000000080000000},  // R4
      {64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFF00, 6'd0, 1'b0, 1'b0, 1'b1, 64'h0123456789ABCDEF}, // R2
      {64'h0123456789ABCDEF, 64'd0, 6'd32, 1'b1, 1'b1, 1'b1, 64'h0000000089ABCDEF}   // R4
   };

   function automatic logic [63:0] ref_perm(input logic [63:0] s, input int k, input bit word);
      logic [63:0] r = '0;
      if (word) for (int i = 0; i < 32; i++) r[i] = s[i ^ (k & 31)];
      else      for (int i = 0; i < 64; i++) r[i] = s[i ^ (k & 63)];
      return r;
   endfunction

   function automatic logic [2:0] ref_flags(input logic [63:0] v, input bit rec);
      if (!rec)       return 3'b000;
      if (v[63])      return 3'b100;
      if (v == 64'h0) return 3'b001;
      return 3'b010;
   endfunction

   task automatic drive(input logic [63:0] s, input logic [63:0] c, input logic [5:0] im,
                        input bit ui, input bit wm, input bit rc);
      src = s; ctl_reg = c; ctl_imm = im; use_imm = ui; word_mode = wm; rec_en = rc;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mix(input logic [63:0] v);
      return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]} ^ 64'h9E3779B97F4A7C15;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [63:0] pat;
      logic [63:0] first;
      drive(64'h0, 64'h0, 6'd0, 1'b0, 1'b0, 1'b0);
      check("idle result R1", result, 64'h0);
      check("idle cond_wr R6", {63'h0, cond_wr}, 64'h0);
      check("idle flags R6", {61'h0, cond_flags}, 64'h0);

      for (int n = 0; n < 8; n++) begin
         drive(TBL[n][200:137], TBL[n][136:73], TBL[n][72:67], TBL[n][66], TBL[n][65], TBL[n][64]);
         check($sformatf("table %0d result R1/R2/R3/R4/R7", n), result, TBL[n][63:0]);
         check($sformatf("table %0d flags R6", n), {61'h0, cond_flags},
               {61'h0, ref_flags(TBL[n][63:0], TBL[n][64])});
         check($sformatf("table %0d cond_wr R6", n), {63'h0, cond_wr}, {63'h0, TBL[n][64]});
      end

      pat = 64'hC3A5_0F1E_7B29_D846;
      for (int k = 0; k < 64; k++) begin
         pat = mix(pat);
         drive(pat, {pat[63:6], 6'(k)}, ~6'(k), 1'b0, 1'b0, 1'b0);
         check($sformatf("R1 R2 reg k=%0d", k), result, ref_perm(pat, k, 1'b0));
         drive(pat, ~pat, 6'(k), 1'b1, 1'b0, 1'b0);
         check($sformatf("R3 imm k=%0d", k), result, ref_perm(pat, k, 1'b0));
         drive(pat, 64'(k), 6'd0, 1'b0, 1'b1, 1'b0);
         check($sformatf("R4 R5 word k=%0d", k), result, ref_perm(pat, k, 1'b1));
      end

      for (int k = 0; k < 64; k += 7) begin
         pat = mix(pat);
         drive(pat, 64'(k), 6'd0, 1'b0, 1'b0, 1'b0);
         first = result;
         drive(first, 64'(k), 6'd0, 1'b0, 1'b0, 1'b0);
         check($sformatf("R8 round trip k=%0d", k), result, pat);
      end

      drive(64'h0000000000000001, 64'd63, 6'd0, 1'b0, 1'b0, 1'b0);
      check("R6 no record flags", {61'h0, cond_flags}, 64'h0);
      drive(64'h0000000000000001, 64'd63, 6'd0, 1'b0, 1'b0, 1'b1);
      check("R6 negative", {61'h0, cond_flags}, 64'h4);
      drive(64'h0, 64'd17, 6'd0, 1'b0, 1'b0, 1'b1);
      check("R6 zero", {61'h0, cond_flags}, 64'h1);
      drive(64'h8000000000000000, 64'd63, 6'd0, 1'b0, 1'b0, 1'b1);
      check("R6 positive", {61'h0, cond_flags}, 64'h2);
      drive(64'hFFFFFFFF00000000, 64'd0, 6'd0, 1'b0, 1'b1, 1'b1);
      check("R5 upper source dropped", result, 64'h0);
      check("R5 zero summary", {61'h0, cond_flags}, 64'h1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule